// File: doc/BRIEF.md
# Interrupt Vector Priority Encoder

This block gathers pending interrupt sources of a serial port controller and presents the most urgent one as a read-only 32-bit vector word. There are sixteen transfer groups, and each has two event flags: one for a finished transfer and one for a suspended transfer. Four port-level conditions are also tracked: error, receive overrun, receive buffer full and transmit buffer empty. Each source is held in a sticky flag that a one-cycle set pulse from the serial engine raises.

The vector is computed combinationally from the flags. A change in any flag therefore shows in the word in the cycle after the set pulse is sampled. A host read of the word clears the flag it names, so the word then moves on to the next pending source. The transmit-empty flag is the exception: a host read leaves it alone, and only a write of a new data word clears it. A mode input selects plain SPI operation or multi-buffer operation. In multi-buffer operation the receive-full and transmit-empty sources are never reported.

Top module: `irq_vector_encoder`

## Requirements
- R1: The vector word has the 5-bit code in bits 5..1 and the type bit in bit 0. Bits 31..6 are always zero. After reset the whole word is zero.
- R2: `irq` is high exactly when the code is nonzero. Code 0 means nothing is pending.
- R3: A pending finished flag of group x (x = 0..15) gives code x+1 with type bit 0. A pending suspended flag of group x gives code x+1 with type bit 1.
- R4: In plain SPI mode (`mib_mode`=0) the port-level sources use these codes: error 11h, receive full 12h, receive overrun 13h, transmit empty 14h.
- R5: While `mib_mode`=1, codes 12h and 14h are never output. Those flags are still latched, and they appear once plain SPI mode is selected again.
- R6: Priority is fixed and the lowest nonzero code wins, so group 0 has the highest priority. Within one group, the suspended flag is reported before the finished flag.
- R7: A host read (`host_rd` high at a clock edge) that returns a group code clears only the flag named by that code. From the next cycle the word shows the next pending source.
- R8: A host read that returns code 11h, 12h or 13h clears that flag.
- R9: A host read that returns 14h does not clear the transmit-empty flag. A `data_wr` pulse clears it.
- R10: A set pulse for a flag in the same cycle as that flag's clear (by read or by data write) takes precedence: the flag stays set.
- R11: A set pulse sampled at a clock edge is visible in the vector right after that edge, with no further latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mib_mode | input | 1 | 0 = plain SPI mode, 1 = multi-buffer mode |
| tg_fin_set | input | NUM_GROUPS (16) | Finished-flag set pulses, one per transfer group |
| tg_susp_set | input | NUM_GROUPS (16) | Suspended-flag set pulses, one per transfer group |
| err_set | input | 1 | Error flag set pulse |
| rxovr_set | input | 1 | Receive overrun flag set pulse |
| rxfull_set | input | 1 | Receive buffer full flag set pulse |
| txempty_set | input | 1 | Transmit buffer empty flag set pulse |
| host_rd | input | 1 | Host read strobe of the vector word |
| data_wr | input | 1 | Strobe for a write of a new transmit data word |
| vec_word | output | WORD_W (32) | Vector word: code in bits 5..1, type bit in bit 0 |
| irq | output | 1 | Interrupt line, high while any reported source is pending |

## Verification
A clear and a set of the same flag can land in one cycle, and set must win. The bench provokes this in two ways. First, it raises `host_rd` while the word names group 5 and pulses that group's finished-flag set in the same cycle. Second, it pulses `data_wr` together with `txempty_set` while transmit empty is reported. In both cases the word must still name the same source after the edge, and a later lone read or write must then clear it. That later clear shows the flag was set again rather than never cleared.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

   localparam int VEC_W     = 5;
   localparam int MAX_GROUP = 16;

   typedef logic [VEC_W-1:0] vec_code_t;

   localparam vec_code_t CODE_NONE    = 5'h00;
   localparam vec_code_t CODE_ERR     = 5'h11;
   localparam vec_code_t CODE_RXFULL  = 5'h12;
   localparam vec_code_t CODE_RXOVR   = 5'h13;
   localparam vec_code_t CODE_TXEMPTY = 5'h14;

   // port-level condition flags, one bit each
   typedef struct packed {
      logic err;
      logic rxfull;
      logic rxovr;
      logic txempty;
   } misc_flags_t;

   localparam int MISC_N = $bits(misc_flags_t);

   function automatic vec_code_t group_code(input int idx);
      return vec_code_t'(idx + 1);
   endfunction

endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q_o <= 1'b0;
      else if (set_i)
         q_o <= 1'b1;
      else if (clr_i)
         q_o <= 1'b0;
   end

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);

   // R7
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
   import irq_vec_pkg::*;
#(
   parameter int NUM_GROUPS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_GROUPS-1:0] fin_set,
   input  logic [NUM_GROUPS-1:0] susp_set,
   input  logic [NUM_GROUPS-1:0] fin_clr,
   input  logic [NUM_GROUPS-1:0] susp_clr,
   input  misc_flags_t           misc_set,
   input  misc_flags_t           misc_clr,
   output logic [NUM_GROUPS-1:0] fin_q,
   output logic [NUM_GROUPS-1:0] susp_q,
   output misc_flags_t           misc_q
);

   logic [MISC_N-1:0] misc_set_v;
   logic [MISC_N-1:0] misc_clr_v;
   logic [MISC_N-1:0] misc_q_v;

   assign misc_set_v = misc_set;
   assign misc_clr_v = misc_clr;
   assign misc_q     = misc_flags_t'(misc_q_v);

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
      irq_flag_cell u_fin (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (fin_set[g]),
         .clr_i (fin_clr[g]),
         .q_o   (fin_q[g])
      );
      irq_flag_cell u_susp (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (susp_set[g]),
         .clr_i (susp_clr[g]),
         .q_o   (susp_q[g])
      );
   end

   for (genvar m = 0; m < MISC_N; m++) begin : g_misc
      irq_flag_cell u_cond (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (misc_set_v[m]),
         .clr_i (misc_clr_v[m]),
         .q_o   (misc_q_v[m])
      );
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
   import irq_vec_pkg::*;
#(
   parameter int NUM_GROUPS = 16
) (
   input  logic [NUM_GROUPS-1:0] fin_q,
   input  logic [NUM_GROUPS-1:0] susp_q,
   input  misc_flags_t           misc_q,
   input  logic                  mib_mode,
   output vec_code_t             code,
   output logic                  susp_bit,
   output logic [NUM_GROUPS-1:0] sel_fin,
   output logic [NUM_GROUPS-1:0] sel_susp,
   output misc_flags_t           sel_misc
);

   // receive-full and transmit-empty are hidden in multi-buffer mode
   misc_flags_t eligible;

   always_comb begin
      eligible         = misc_q;
      eligible.rxfull  = misc_q.rxfull  & ~mib_mode;
      eligible.txempty = misc_q.txempty & ~mib_mode;
   end

   always_comb begin
      logic found;
      found    = 1'b0;
      code     = CODE_NONE;
      susp_bit = 1'b0;
      sel_fin  = '0;
      sel_susp = '0;
      sel_misc = '0;
      // ascending scan: the first hit is the lowest code
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (!found && susp_q[g]) begin
            sel_susp[g] = 1'b1;
            code        = group_code(g);
            susp_bit    = 1'b1;
            found       = 1'b1;
         end else if (!found && fin_q[g]) begin
            sel_fin[g] = 1'b1;
            code       = group_code(g);
            found      = 1'b1;
         end
      end
      if (!found && eligible.err) begin
         sel_misc.err = 1'b1;
         code         = CODE_ERR;
         found        = 1'b1;
      end
      if (!found && eligible.rxfull) begin
         sel_misc.rxfull = 1'b1;
         code            = CODE_RXFULL;
         found           = 1'b1;
      end
      if (!found && eligible.rxovr) begin
         sel_misc.rxovr = 1'b1;
         code           = CODE_RXOVR;
         found          = 1'b1;
      end
      if (!found && eligible.txempty) begin
         sel_misc.txempty = 1'b1;
         code             = CODE_TXEMPTY;
      end
   end

endmodule

// File: rtl/irq_vector_encoder.sv
module irq_vector_encoder
   import irq_vec_pkg::*;
#(
   parameter int NUM_GROUPS = 16,
   parameter int WORD_W     = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mib_mode,
   input  logic [NUM_GROUPS-1:0] tg_fin_set,
   input  logic [NUM_GROUPS-1:0] tg_susp_set,
   input  logic                  err_set,
   input  logic                  rxovr_set,
   input  logic                  rxfull_set,
   input  logic                  txempty_set,
   input  logic                  host_rd,
   input  logic                  data_wr,
   output logic [WORD_W-1:0]     vec_word,
   output logic                  irq
);

   localparam int CODE_LSB = 1;
   localparam int USED_W   = CODE_LSB + VEC_W;

   if (NUM_GROUPS < 1 || NUM_GROUPS > MAX_GROUP) begin : g_bad_groups
      $error("NUM_GROUPS must lie in 1..16 so group codes stay below 11h");
   end
   if (WORD_W < USED_W) begin : g_bad_word
      $error("WORD_W too narrow for code and type bit");
   end

   logic [NUM_GROUPS-1:0] fin_q, susp_q;
   logic [NUM_GROUPS-1:0] sel_fin, sel_susp;
   logic [NUM_GROUPS-1:0] fin_clr, susp_clr;
   misc_flags_t           misc_q, sel_misc, misc_set, misc_clr;
   vec_code_t             code;
   logic                  susp_bit;

   always_comb begin
      misc_set.err     = err_set;
      misc_set.rxfull  = rxfull_set;
      misc_set.rxovr   = rxovr_set;
      misc_set.txempty = txempty_set;
   end

   // read-to-clear hits only the source the word names; data write owns txempty
   assign fin_clr  = sel_fin  & {NUM_GROUPS{host_rd}};
   assign susp_clr = sel_susp & {NUM_GROUPS{host_rd}};

   always_comb begin
      misc_clr.err     = host_rd & sel_misc.err;
      misc_clr.rxfull  = host_rd & sel_misc.rxfull;
      misc_clr.rxovr   = host_rd & sel_misc.rxovr;
      misc_clr.txempty = data_wr;
   end

   irq_flag_bank #(
      .NUM_GROUPS (NUM_GROUPS)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .fin_set  (tg_fin_set),
      .susp_set (tg_susp_set),
      .fin_clr  (fin_clr),
      .susp_clr (susp_clr),
      .misc_set (misc_set),
      .misc_clr (misc_clr),
      .fin_q    (fin_q),
      .susp_q   (susp_q),
      .misc_q   (misc_q)
   );

   irq_prio_pick #(
      .NUM_GROUPS (NUM_GROUPS)
   ) u_pick (
      .fin_q    (fin_q),
      .susp_q   (susp_q),
      .misc_q   (misc_q),
      .mib_mode (mib_mode),
      .code     (code),
      .susp_bit (susp_bit),
      .sel_fin  (sel_fin),
      .sel_susp (sel_susp),
      .sel_misc (sel_misc)
   );

   always_comb begin
      vec_word                      = '0;
      vec_word[CODE_LSB +: VEC_W]   = code;
      vec_word[0]                   = susp_bit;
   end

   assign irq = |code;

   // R5
   mib_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mib_mode |-> (code != CODE_RXFULL && code != CODE_TXEMPTY));

   // R6
   one_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_fin, sel_susp, sel_misc}));

   // R6
   group_over_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (misc_q.err && !(|fin_q) && !(|susp_q)) |-> (code == CODE_ERR));

   // R9
   txe_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && code == CODE_TXEMPTY && !data_wr) |=> misc_q.txempty);

   // R9
   wr_clears_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !txempty_set) |=> !misc_q.txempty);

   // R7
   read_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && code != CODE_NONE && code != CODE_TXEMPTY && !(|tg_fin_set)
       && !(|tg_susp_set) && !err_set && !rxovr_set && !rxfull_set && !txempty_set)
      |=> ((vec_word != $past(vec_word)) || (mib_mode != $past(mib_mode))));

   // R1
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_word[WORD_W-1:USED_W] == '0);

endmodule

// File: tb/irq_vector_encoder_tb.sv
module irq_vector_encoder_tb;

   localparam int NG = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mib_mode = 1'b0;
   logic [NG-1:0] tg_fin_set = '0;
   logic [NG-1:0] tg_susp_set = '0;
   logic          err_set = 1'b0, rxovr_set = 1'b0, rxfull_set = 1'b0, txempty_set = 1'b0;
   logic          host_rd = 1'b0, data_wr = 1'b0;
   logic [31:0]   vec_word;
   logic          irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   irq_vector_encoder #(.NUM_GROUPS(NG), .WORD_W(32)) u_dut (
      .clk (clk), .rst_n (rst_n), .mib_mode (mib_mode),
      .tg_fin_set (tg_fin_set), .tg_susp_set (tg_susp_set),
      .err_set (err_set), .rxovr_set (rxovr_set), .rxfull_set (rxfull_set),
      .txempty_set (txempty_set), .host_rd (host_rd), .data_wr (data_wr),
      .vec_word (vec_word), .irq (irq)
   );

   function automatic logic [31:0] w(input int code, input bit s);
      return (32'(code) << 1) | 32'(s);
   endfunction

   // driver: push expectation, let one edge pass, then drop pulses after the monitor sampled
   task automatic tick(input logic [31:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(posedge clk);
      #4;
      tg_fin_set = '0; tg_susp_set = '0;
      err_set = 0; rxovr_set = 0; rxfull_set = 0; txempty_set = 0;
      host_rd = 0; data_wr = 0;
   endtask

   // monitor: compare word and interrupt line 2 ns after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (vec_word !== e || irq !== (e[5:1] != 5'd0)) begin
               errors++;
               $display("FAIL %s: word=%h irq=%b expected word=%h irq=%b",
                        t, vec_word, irq, e, (e[5:1] != 5'd0));
            end
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #4 rst_n = 1'b1;
      tick(32'h0, "R1 reset word zero");
      tick(32'h0, "R2 idle no irq");
      tg_fin_set[3] = 1;           tick(w(4, 0), "R3 R11 group3 finished");
      host_rd = 1;                 tick(32'h0, "R7 read clears group3");
      tg_susp_set[15] = 1;         tick(w(16, 1), "R3 group15 suspended");
      tg_fin_set[15] = 1;          tick(w(16, 1), "R6 suspended before finished");
      host_rd = 1;                 tick(w(16, 0), "R7 read clears suspended only");
      host_rd = 1;                 tick(32'h0, "R7 read clears finished");
      err_set = 1; rxovr_set = 1; rxfull_set = 1; txempty_set = 1;
                                   tick(w(17, 0), "R4 error code 11h");
      tg_fin_set[0] = 1;           tick(w(1, 0), "R6 group0 over error");
      host_rd = 1;                 tick(w(17, 0), "R7 group0 cleared");
      host_rd = 1;                 tick(w(18, 0), "R8 error cleared, rxfull 12h");
      host_rd = 1;                 tick(w(19, 0), "R8 rxfull cleared, overrun 13h");
      host_rd = 1;                 tick(w(20, 0), "R8 overrun cleared, txempty 14h");
      host_rd = 1;                 tick(w(20, 0), "R9 read keeps txempty");
      data_wr = 1;                 tick(32'h0, "R9 data write clears txempty");
      tg_fin_set[5] = 1;           tick(w(6, 0), "R3 group5 finished");
      host_rd = 1; tg_fin_set[5] = 1;
                                   tick(w(6, 0), "R10 set beats read clear");
      host_rd = 1;                 tick(32'h0, "R10 later read clears group5");
      txempty_set = 1;             tick(w(20, 0), "R4 txempty alone");
      data_wr = 1; txempty_set = 1;
                                   tick(w(20, 0), "R10 set beats data write");
      data_wr = 1;                 tick(32'h0, "R10 later write clears txempty");
      mib_mode = 1; txempty_set = 1; rxfull_set = 1;
                                   tick(32'h0, "R5 mib hides 12h and 14h");
      host_rd = 1;                 tick(32'h0, "R5 empty read in mib");
      mib_mode = 0;                tick(w(18, 0), "R5 spi shows latched rxfull");
      host_rd = 1;                 tick(w(20, 0), "R8 rxfull cleared");
      data_wr = 1;                 tick(32'h0, "R9 txempty cleared");
      mib_mode = 1; err_set = 1; tg_susp_set[2] = 1;
                                   tick(w(3, 1), "R3 group2 suspended in mib");
      host_rd = 1;                 tick(w(17, 0), "R7 mib error after group");
      host_rd = 1;                 tick(32'h0, "R8 mib error cleared");
      mib_mode = 0;                tick(32'h0, "R2 all clear");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not end, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule